// File: doc/BRIEF.md
# Pattern-Unlock Serial Register Access Controller

This controller sits between a host's memory strobes (chip enable, output enable, write enable and a single data bit) and the chip enable of an external SRAM. It needs no address space of its own. Access is gained by writing a secret 64-bit key, one bit per write cycle. Until the key has been fully matched, every host access is passed on to the SRAM. Once the key matches, the following 64 host cycles are claimed by the controller. Each claimed cycle moves one bit of a 64-bit clock register image: write cycles shift a bit in, and read cycles drive a bit out. The SRAM is deselected during all of these cycles.

A read cycle arms recognition by pointing at the first key bit. Any later read restarts recognition. A single mismatching write freezes the pointer, and the rest of that attempt is then ignored. Host strobes are synchronised to the system clock, and a cycle counts when chip enable deasserts. Written bits are collected in a shadow register and committed only when all 64 have arrived. A power-fail input deselects the SRAM at once. It also drops any attempt or transfer without changing the registers, and it ignores the host while it is active.

Top module: `phantom_unlock_ctrl`

## Requirements
- R1: During and after reset the SRAM enable follows the host chip enable, the serial output enable is low and the register image is all zeros.
- R2: While the key is not fully matched, `ce_out_n` equals `ce_in_n` for every host read or write cycle.
- R3: A read cycle (CE low, OE low, WE high) arms recognition at key bit 0. Writes (CE low, WE low) carrying key bits 0 to 63 in order, LSB first, then unlock transfer mode.
- R4: After one mismatching write, later writes are ignored until a read. Even a complete correct key written afterwards does not unlock.
- R5: A read during recognition resets the pointer, and a full key written after it unlocks.
- R6: Writes made when no read has armed recognition never unlock.
- R7: In transfer mode, the n-th read cycle (n = 0 to 63) drives image bit n on `q_out`, with `q_oe` high while that read strobe is active, and `ce_out_n` stays high.
- R8: Bits written in transfer mode appear in the image only after the 64th transfer cycle. Bit n takes the value written in cycle n, and bits whose cycle was a read keep their value.
- R9: After 64 transfer cycles the controller returns to pass-through, and a new read is needed to arm again.
- R10: While `pwr_fail` is high, `ce_out_n` is high and host cycles are ignored. A transfer in progress is dropped with the image unchanged, and the controller is locked when power returns.
- R11: Strobe activity with `ce_in_n` high does not disturb recognition or transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_in_n | input | 1 | Host chip enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| we_n | input | 1 | Host write enable, active low |
| d_in | input | 1 | Serial data bit from host |
| pwr_fail | input | 1 | Power-fail indication, active high |
| ce_out_n | output | 1 | SRAM chip enable, active low |
| q_out | output | 1 | Serial data bit to host |
| q_oe | output | 1 | Drive enable for `q_out` |
| clk_image | output | 64 | Clock register image |

## Verification
The assertions watch several rules on every cycle. Power-fail always deselects the SRAM and clears any attempt. A failed attempt keeps its pointer frozen until a read. The transfer counter moves only on claimed cycles. The register image changes only on the commit cycle. Serial output is enabled only in transfer mode. Other behaviour needs the bench's scenarios: that the key is matched LSB first, that a late read restarts matching, that writes before any read never unlock, that read data comes out in bit order, and that strobes with chip enable high leave both sequences intact.

// File: rtl/phantom_unlock_ctrl.sv
module phantom_unlock_ctrl #(
  parameter int N = 64,
  parameter logic [N-1:0] KEY = 64'hC3A5_5A3C_96E1_1E69,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce_in_n,
  input  logic         oe_n,
  input  logic         we_n,
  input  logic         d_in,
  input  logic         pwr_fail,
  output logic         ce_out_n,
  output logic         q_out,
  output logic         q_oe,
  output logic [N-1:0] clk_image
);
  localparam int PW = $clog2(N);
  localparam logic [PW-1:0] LAST = PW'(N - 1);

  typedef enum logic [1:0] {M_IDLE, M_HUNT, M_XFER} mode_t;

  logic [SYNC_STAGES-1:0] ce_sr, oe_sr, we_sr, d_sr, pf_sr;
  logic ce_s, oe_s, we_s, d_s, pf_s, ce_d;
  logic cyc_rd, cyc_wr, cyc_d;
  logic end_evt, rd_evt, wr_evt, xfer_evt;
  mode_t mode;
  logic [PW-1:0] ptr, xcnt;
  logic miss;
  logic [N-1:0] shadow, stage;
  logic in_hunt, in_xfer;

  assign ce_s = ce_sr[SYNC_STAGES-1];
  assign oe_s = oe_sr[SYNC_STAGES-1];
  assign we_s = we_sr[SYNC_STAGES-1];
  assign d_s  = d_sr[SYNC_STAGES-1];
  assign pf_s = pf_sr[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ce_sr <= '1;
      oe_sr <= '1;
      we_sr <= '1;
      d_sr  <= '0;
      pf_sr <= '0;
      ce_d  <= 1'b1;
    end else begin
      ce_sr <= {ce_sr[SYNC_STAGES-2:0], ce_in_n};
      oe_sr <= {oe_sr[SYNC_STAGES-2:0], oe_n};
      we_sr <= {we_sr[SYNC_STAGES-2:0], we_n};
      d_sr  <= {d_sr[SYNC_STAGES-2:0], d_in};
      pf_sr <= {pf_sr[SYNC_STAGES-2:0], pwr_fail};
      ce_d  <= ce_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cyc_rd <= 1'b0;
      cyc_wr <= 1'b0;
      cyc_d  <= 1'b0;
    end else if (!ce_s) begin
      cyc_wr <= ~we_s;
      cyc_rd <= we_s & ~oe_s;
      cyc_d  <= d_s;
    end

  assign end_evt  = ce_s & ~ce_d & ~pf_s;
  assign rd_evt   = end_evt & cyc_rd;
  assign wr_evt   = end_evt & cyc_wr;
  assign xfer_evt = rd_evt | wr_evt;
  assign in_hunt  = (mode == M_HUNT);
  assign in_xfer  = (mode == M_XFER);

  always_comb begin
    stage = shadow;
    stage[xcnt] = cyc_wr ? cyc_d : clk_image[xcnt];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode      <= M_IDLE;
      ptr       <= '0;
      xcnt      <= '0;
      miss      <= 1'b0;
      shadow    <= '0;
      clk_image <= '0;
    end else if (pf_s) begin
      mode <= M_IDLE;
      ptr  <= '0;
      xcnt <= '0;
      miss <= 1'b0;
    end else begin
      case (mode)
        M_IDLE:
          if (rd_evt) begin
            mode <= M_HUNT;
            ptr  <= '0;
            miss <= 1'b0;
          end
        M_HUNT:
          if (rd_evt) begin
            ptr  <= '0;
            miss <= 1'b0;
          end else if (wr_evt && !miss) begin
            if (cyc_d == KEY[ptr]) begin
              if (ptr == LAST) begin
                mode <= M_XFER;
                ptr  <= '0;
                xcnt <= '0;
              end else begin
                ptr <= ptr + 1'b1;
              end
            end else begin
              miss <= 1'b1;
            end
          end
        M_XFER:
          if (xfer_evt) begin
            shadow <= stage;
            if (xcnt == LAST) begin
              clk_image <= stage;
              mode      <= M_IDLE;
              xcnt      <= '0;
            end else begin
              xcnt <= xcnt + 1'b1;
            end
          end
        default: mode <= M_IDLE;
      endcase
    end

  assign ce_out_n = ce_in_n | pwr_fail | in_xfer;
  assign q_out    = clk_image[xcnt];
  assign q_oe     = in_xfer & ~ce_in_n & ~oe_n & we_n & ~pwr_fail;
endmodule

// File: rtl/phantom_unlock_chk.sv
module phantom_unlock_chk #(
  parameter int N = 64,
  parameter int PW = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pwr_fail,
  input logic         ce_out_n,
  input logic         q_oe,
  input logic         pf_s,
  input logic         in_hunt,
  input logic         in_xfer,
  input logic         miss,
  input logic         rd_evt,
  input logic         xfer_evt,
  input logic [PW-1:0] ptr,
  input logic [PW-1:0] xcnt,
  input logic [N-1:0] clk_image
);
  assert_pf_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> ce_out_n);

  assert_pf_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pf_s |=> (!in_hunt && !in_xfer));

  assert_miss_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hunt && miss && !rd_evt && !pf_s) |=> (in_hunt && miss && $stable(ptr)));

  assert_image_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_xfer && xfer_evt && xcnt == PW'(N - 1)) |=> $stable(clk_image));

  assert_qoe_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_oe |-> (in_xfer && ce_out_n));

  assert_xcnt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && !xfer_evt && !pf_s) |=> (in_xfer && $stable(xcnt)));
endmodule

bind phantom_unlock_ctrl phantom_unlock_chk #(.N(N), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .ce_out_n(ce_out_n),
  .q_oe(q_oe), .pf_s(pf_s), .in_hunt(in_hunt), .in_xfer(in_xfer),
  .miss(miss), .rd_evt(rd_evt), .xfer_evt(xfer_evt), .ptr(ptr),
  .xcnt(xcnt), .clk_image(clk_image)
);

// File: tb/tb_phantom_unlock_ctrl.sv
module tb_phantom_unlock_ctrl;
  localparam logic [63:0] KEY = 64'hC3A5_5A3C_96E1_1E69;
  localparam logic [63:0] P1  = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] P2  = 64'hF0E1_D2C3_B4A5_9687;
  localparam logic [63:0] P3  = 64'hFFFF_FFFF_FFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_in_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, d_in = 1'b0, pwr_fail = 1'b0;
  logic ce_out_n, q_out, q_oe;
  logic [63:0] clk_image;
  int total = 0, bad = 0;
  logic q_s, qoe_s;

  always #10 clk = ~clk;

  phantom_unlock_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ce_in_n(ce_in_n), .oe_n(oe_n), .we_n(we_n),
    .d_in(d_in), .pwr_fail(pwr_fail), .ce_out_n(ce_out_n), .q_out(q_out),
    .q_oe(q_oe), .clk_image(clk_image)
  );

  typedef struct packed {
    logic [1:0] op;
    logic       d;
    logic       ceo;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd1, 1'b0, 1'b0}, '{2'd1, 1'b1, 1'b0}, '{2'd2, 1'b1, 1'b1},
    '{2'd0, 1'b0, 1'b0}, '{2'd1, 1'b0, 1'b0}, '{2'd2, 1'b0, 1'b1},
    '{2'd0, 1'b0, 1'b0}, '{2'd1, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // op 0 read, 1 write, 2 strobes with chip enable high
  task automatic do_cyc(input int op, input logic d, input logic exp_ceo, input string req);
    @(negedge clk);
    d_in = d;
    oe_n = (op == 0) ? 1'b0 : 1'b1;
    we_n = (op == 0) ? 1'b1 : 1'b0;
    if (op != 2) ce_in_n = 1'b0;
    repeat (4) @(negedge clk);
    q_s = q_out;
    qoe_s = q_oe;
    chk(ce_out_n == exp_ceo, req, {63'd0, ce_out_n}, {63'd0, exp_ceo});
    ce_in_n = 1'b1;
    repeat (3) @(negedge clk);
    oe_n = 1'b1;
    we_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic unlock(input string req);
    do_cyc(0, 1'b0, 1'b0, req);
    for (int i = 0; i < 64; i++) do_cyc(1, KEY[i], 1'b0, "R2");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: in reset
    repeat (2) @(negedge clk);
    ce_in_n = 1'b0;
    @(negedge clk);
    chk(ce_out_n == 1'b0 && !q_oe, "R1", {63'd0, ce_out_n}, 64'd0);
    ce_in_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ce_out_n && !q_oe && clk_image == 64'd0, "R1", clk_image, 64'd0);

    // R2 pass-through vector table
    for (int v = 0; v < 8; v++)
      do_cyc(int'(VEC[v].op), VEC[v].d, VEC[v].ceo, "R2");

    // R3 unlock then R7/R8 write transfer
    unlock("R3");
    for (int i = 0; i < 64; i++) begin
      do_cyc(1, P1[i], 1'b1, "R3");
      if (i == 62) chk(clk_image == 64'd0, "R8", clk_image, 64'd0);
    end
    chk(clk_image == P1, "R8", clk_image, P1);
    do_cyc(1, 1'b0, 1'b0, "R9");

    // R7 read transfer
    unlock("R3");
    for (int i = 0; i < 64; i++) begin
      do_cyc(0, 1'b0, 1'b1, "R7");
      chk(q_s == P1[i] && qoe_s, "R7", {62'd0, qoe_s, q_s}, {62'd0, 1'b1, P1[i]});
    end
    chk(clk_image == P1, "R8", clk_image, P1);

    // R6 no read to arm
    for (int i = 0; i < 64; i++) do_cyc(1, KEY[i], 1'b0, "R6");
    do_cyc(1, 1'b0, 1'b0, "R6");

    // R4 mismatch sticks
    do_cyc(0, 1'b0, 1'b0, "R4");
    for (int i = 0; i < 5; i++) do_cyc(1, KEY[i], 1'b0, "R4");
    do_cyc(1, ~KEY[5], 1'b0, "R4");
    for (int i = 0; i < 64; i++) do_cyc(1, KEY[i], 1'b0, "R4");
    do_cyc(1, 1'b0, 1'b0, "R4");

    // R5 read restarts recognition
    do_cyc(0, 1'b0, 1'b0, "R5");
    for (int i = 0; i < 10; i++) do_cyc(1, KEY[i], 1'b0, "R5");
    do_cyc(0, 1'b0, 1'b0, "R5");
    for (int i = 0; i < 64; i++) do_cyc(1, KEY[i], 1'b0, "R5");
    for (int i = 0; i < 64; i++) begin
      do_cyc(0, 1'b0, 1'b1, "R5");
      chk(q_s == P1[i], "R5", {63'd0, q_s}, {63'd0, P1[i]});
    end

    // R11 interleaved strobes without chip enable
    do_cyc(0, 1'b0, 1'b0, "R11");
    for (int i = 0; i < 64; i++) begin
      do_cyc(2, ~KEY[i], 1'b1, "R11");
      do_cyc(1, KEY[i], 1'b0, "R11");
    end
    for (int i = 0; i < 64; i++) begin
      do_cyc(2, ~P2[i], 1'b1, "R11");
      do_cyc(1, P2[i], 1'b1, "R11");
    end
    chk(clk_image == P2, "R11", clk_image, P2);

    // R10 power fail aborts a transfer
    unlock("R10");
    for (int i = 0; i < 30; i++) do_cyc(1, P3[i], 1'b1, "R10");
    @(negedge clk);
    pwr_fail = 1'b1;
    @(negedge clk);
    ce_in_n = 1'b0;
    @(negedge clk);
    chk(ce_out_n == 1'b1, "R10", {63'd0, ce_out_n}, 64'd1);
    ce_in_n = 1'b1;
    repeat (4) @(negedge clk);
    do_cyc(0, 1'b0, 1'b1, "R10");
    for (int i = 0; i < 64; i++) do_cyc(1, KEY[i], 1'b1, "R10");
    pwr_fail = 1'b0;
    repeat (6) @(negedge clk);
    chk(clk_image == P2, "R10", clk_image, P2);
    for (int i = 0; i < 34; i++) do_cyc(1, P3[i], 1'b0, "R10");
    chk(clk_image == P2, "R10", clk_image, P2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule